// File: doc/BRIEF.md
# Hardware Mutex Unit with Thread Suspension

This unit arbitrates mutual exclusion among the hardware threads of two multithreaded processors. Each processor has four threads, so the unit serves eight requesters. A processor turns a lock or unlock flag, taken from the instruction it is executing, into a request on its own valid/ready channel. The request names the local thread and one of sixteen mutex identifiers. For each mutex the unit keeps a held bit, the global ID of the owner and a mask of waiting threads.

The unit does not ask a thread to spin when a mutex is taken. It answers SUSPEND, and the processor's scheduler parks that thread. When the owner releases a mutex that has waiters, the unit picks one waiter and makes it the owner at once. It then sends a one-cycle resume pulse to the processor that runs the chosen thread, which may be the other processor. The scheduler can restart the thread with the lock already held.

The unit accepts one request per cycle. The response appears one cycle after the request is accepted. A processor must hold valid and all request fields stable until it sees ready. Ready for a processor is high only when no processor with a lower index is presenting a request. Response and resume pins carry no back-pressure and are single-cycle pulses.

Top module: `hw_mutex_unit`

## Requirements
- R1: After reset every mutex is free with no waiters, and rsp_valid and resume_valid are all low.
- R2: A lock on a free mutex answers GRANT (rsp_code 1). The requesting thread becomes owner.
- R3: A lock on a mutex held by another thread answers SUSPEND (rsp_code 2). The requester is recorded as a waiter, and the owner is unchanged.
- R4: An unlock by the owner of a mutex with no waiters answers DONE (rsp_code 0) and frees the mutex.
- R5: An unlock by the owner when waiters exist answers DONE. Ownership passes to the first waiter found in increasing global thread order, starting one after the releasing thread and wrapping from 7 to 0. Exactly one resume pulse is raised, for that thread only.
- R6: An unlock on a free mutex, or by a thread that is not the owner, answers ERROR (rsp_code 3) and changes no state.
- R7: A lock by the current owner of that mutex answers ERROR (rsp_code 3) and changes no state.
- R8: When both processors present a request in the same cycle, processor 0 is accepted. Processor 1 sees ready low, keeps its request, and is accepted in the next cycle.
- R9: A request is accepted when valid and ready are both high. rsp_valid for that processor is high for exactly the next cycle, with rsp_thread echoing the local thread. There is no response in any other cycle.
- R10: The global thread ID is processor index × 4 + local thread. resume_thread carries the local part on the resume_valid bit of the owning processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Request present, one bit per processor |
| req_ready | output | 2 | Request accepted this cycle, one bit per processor |
| req_unlock | input | 2 | 1 = unlock, 0 = lock, per processor |
| req_thread | input | 4 | Local thread ID, 2 bits per processor |
| req_mutex | input | 8 | Mutex ID, 4 bits per processor |
| rsp_valid | output | 2 | Response pulse, one bit per processor |
| rsp_code | output | 4 | 0 DONE, 1 GRANT, 2 SUSPEND, 3 ERROR; 2 bits per processor |
| rsp_thread | output | 4 | Local thread the response belongs to |
| resume_valid | output | 2 | Wake pulse to the processor's scheduler |
| resume_thread | output | 4 | Local thread to wake, 2 bits per processor |

## Verification
The bench sweeps every mutex against every owner. It queues the seven other threads as waiters in a scattered order, then drains the queue one unlock at a time. This exposes a hand-off that restarts its search at thread 0 instead of after the releaser, and a picker that skips the wrap from 7 to 0. Both would resume the wrong thread or wake a thread on the wrong processor. Re-locks by the owner, unlocks by a waiter and unlocks of a free mutex are mixed into the sweep. The following operations show any state an erroneous request disturbed as a wrong GRANT or SUSPEND. A same-cycle collision between the processors catches an arbiter that drops or duplicates the losing request.

// File: rtl/hmu_pkg.sv
package hmu_pkg;
  typedef enum logic [1:0] {
    RSP_DONE    = 2'd0,
    RSP_GRANT   = 2'd1,
    RSP_SUSPEND = 2'd2,
    RSP_ERROR   = 2'd3
  } rsp_code_e;
endpackage

// File: rtl/hmu_arbiter.sv
module hmu_arbiter #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pri
      if (g == 0) begin : g_top
        assign grant[g] = valid[g];
      end else begin : g_low
        assign grant[g] = valid[g] & ~(|valid[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid[i]) idx = IW'(i);
    end
  end

  assign any = |valid;
endmodule

// File: rtl/hmu_waiter_pick.sv
module hmu_waiter_pick #(
  parameter int NUM_THR = 8,
  localparam int TID_W = $clog2(NUM_THR)
) (
  input  logic [NUM_THR-1:0] mask,
  input  logic [TID_W-1:0]   start,
  output logic               found,
  output logic [TID_W-1:0]   pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 1; i <= NUM_THR; i++) begin
      logic [TID_W-1:0] cand;
      cand = start + TID_W'(i);
      if (!found && mask[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end
endmodule

// File: rtl/hmu_mutex_table.sv
module hmu_mutex_table #(
  parameter int NUM_MUTEX = 16,
  parameter int NUM_THR   = 8,
  localparam int MID_W = $clog2(NUM_MUTEX),
  localparam int TID_W = $clog2(NUM_THR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MID_W-1:0]   idx,
  output logic               rd_held,
  output logic [TID_W-1:0]   rd_owner,
  output logic [NUM_THR-1:0] rd_waiters,
  input  logic               wr_en,
  input  logic               wr_held,
  input  logic [TID_W-1:0]   wr_owner,
  input  logic [NUM_THR-1:0] wr_waiters
);
  logic [NUM_MUTEX-1:0] held_q;
  logic [TID_W-1:0]     owner_q [NUM_MUTEX];
  logic [NUM_THR-1:0]   wait_q  [NUM_MUTEX];

  genvar g;
  generate
    for (g = 0; g < NUM_MUTEX; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held_q[g]  <= 1'b0;
          owner_q[g] <= '0;
          wait_q[g]  <= '0;
        end else if (wr_en && idx == MID_W'(g)) begin
          held_q[g]  <= wr_held;
          owner_q[g] <= wr_owner;
          wait_q[g]  <= wr_waiters;
        end
      end

      // a free mutex never keeps sleepers behind it
      p_free_no_waiters_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !held_q[g] |-> (wait_q[g] == '0));
      // the owner is never queued on its own mutex
      p_owner_not_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n)
        held_q[g] |-> !wait_q[g][owner_q[g]]);
    end
  endgenerate

  assign rd_held    = held_q[idx];
  assign rd_owner   = owner_q[idx];
  assign rd_waiters = wait_q[idx];
endmodule

// File: rtl/hmu_resp_reg.sv
module hmu_resp_reg
  import hmu_pkg::*;
#(
  parameter int NUM_PROC = 2,
  parameter int LTID_W   = 2,
  localparam int PW = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fire,
  input  logic [PW-1:0]                fire_idx,
  input  rsp_code_e                    code,
  input  logic [LTID_W-1:0]            lt,
  input  logic                         res_fire,
  input  logic [PW-1:0]                res_idx,
  input  logic [LTID_W-1:0]            res_lt,
  output logic [NUM_PROC-1:0]          rsp_valid,
  output logic [2*NUM_PROC-1:0]        rsp_code,
  output logic [NUM_PROC*LTID_W-1:0]   rsp_thread,
  output logic [NUM_PROC-1:0]          resume_valid,
  output logic [NUM_PROC*LTID_W-1:0]   resume_thread
);
  genvar g;
  generate
    for (g = 0; g < NUM_PROC; g++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rsp_valid[g]                       <= 1'b0;
          rsp_code[2*g +: 2]                 <= 2'd0;
          rsp_thread[g*LTID_W +: LTID_W]     <= '0;
          resume_valid[g]                    <= 1'b0;
          resume_thread[g*LTID_W +: LTID_W]  <= '0;
        end else begin
          rsp_valid[g]    <= fire && fire_idx == PW'(g);
          resume_valid[g] <= res_fire && res_idx == PW'(g);
          if (fire && fire_idx == PW'(g)) begin
            rsp_code[2*g +: 2]             <= code;
            rsp_thread[g*LTID_W +: LTID_W] <= lt;
          end
          if (res_fire && res_idx == PW'(g)) begin
            resume_thread[g*LTID_W +: LTID_W] <= res_lt;
          end
        end
      end
    end
  endgenerate

  p_resume_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resume_valid));
  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
endmodule

// File: rtl/hw_mutex_unit.sv
module hw_mutex_unit
  import hmu_pkg::*;
#(
  parameter int NUM_PROC         = 2,
  parameter int THREADS_PER_PROC = 4,
  parameter int NUM_MUTEX        = 16,
  localparam int PW      = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int LTID_W  = (THREADS_PER_PROC > 1) ? $clog2(THREADS_PER_PROC) : 1,
  localparam int MID_W   = $clog2(NUM_MUTEX),
  localparam int TID_W   = PW + LTID_W,
  localparam int NUM_THR = 1 << TID_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PROC-1:0]         req_valid,
  output logic [NUM_PROC-1:0]         req_ready,
  input  logic [NUM_PROC-1:0]         req_unlock,
  input  logic [NUM_PROC*LTID_W-1:0]  req_thread,
  input  logic [NUM_PROC*MID_W-1:0]   req_mutex,
  output logic [NUM_PROC-1:0]         rsp_valid,
  output logic [2*NUM_PROC-1:0]       rsp_code,
  output logic [NUM_PROC*LTID_W-1:0]  rsp_thread,
  output logic [NUM_PROC-1:0]         resume_valid,
  output logic [NUM_PROC*LTID_W-1:0]  resume_thread
);
  logic [PW-1:0]      sel_idx;
  logic               sel_any;
  logic               sel_unlock;
  logic [LTID_W-1:0]  sel_lt;
  logic [MID_W-1:0]   sel_mid;
  logic [TID_W-1:0]   sel_gtid;

  hmu_arbiter #(.N(NUM_PROC)) u_arb (
    .valid (req_valid),
    .grant (req_ready),
    .idx   (sel_idx),
    .any   (sel_any)
  );

  assign sel_unlock = req_unlock[sel_idx];
  assign sel_lt     = req_thread[sel_idx*LTID_W +: LTID_W];
  assign sel_mid    = req_mutex[sel_idx*MID_W +: MID_W];
  assign sel_gtid   = {sel_idx, sel_lt};

  logic               cur_held;
  logic [TID_W-1:0]   cur_owner;
  logic [NUM_THR-1:0] cur_waiters;
  logic               wr_en;
  logic               nxt_held;
  logic [TID_W-1:0]   nxt_owner;
  logic [NUM_THR-1:0] nxt_waiters;

  hmu_mutex_table #(.NUM_MUTEX(NUM_MUTEX), .NUM_THR(NUM_THR)) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (sel_mid),
    .rd_held    (cur_held),
    .rd_owner   (cur_owner),
    .rd_waiters (cur_waiters),
    .wr_en      (wr_en),
    .wr_held    (nxt_held),
    .wr_owner   (nxt_owner),
    .wr_waiters (nxt_waiters)
  );

  logic             hand_found;
  logic [TID_W-1:0] hand_pick;

  hmu_waiter_pick #(.NUM_THR(NUM_THR)) u_pick (
    .mask  (cur_waiters),
    .start (sel_gtid),
    .found (hand_found),
    .pick  (hand_pick)
  );

  rsp_code_e code;
  logic      res_fire;

  always_comb begin
    code        = RSP_ERROR;
    nxt_held    = cur_held;
    nxt_owner   = cur_owner;
    nxt_waiters = cur_waiters;
    res_fire    = 1'b0;
    if (!sel_unlock) begin
      if (!cur_held) begin
        code      = RSP_GRANT;
        nxt_held  = 1'b1;
        nxt_owner = sel_gtid;
      end else if (cur_owner == sel_gtid) begin
        code = RSP_ERROR;
      end else begin
        code = RSP_SUSPEND;
        nxt_waiters[sel_gtid] = 1'b1;
      end
    end else begin
      if (!cur_held || cur_owner != sel_gtid) begin
        code = RSP_ERROR;
      end else if (hand_found) begin
        code      = RSP_DONE;
        nxt_owner = hand_pick;
        nxt_waiters[hand_pick] = 1'b0;
        res_fire  = sel_any;
      end else begin
        code     = RSP_DONE;
        nxt_held = 1'b0;
      end
    end
    wr_en = sel_any && (code != RSP_ERROR);
  end

  hmu_resp_reg #(.NUM_PROC(NUM_PROC), .LTID_W(LTID_W)) u_rsp (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (sel_any),
    .fire_idx      (sel_idx),
    .code          (code),
    .lt            (sel_lt),
    .res_fire      (res_fire),
    .res_idx       (hand_pick[TID_W-1 -: PW]),
    .res_lt        (hand_pick[LTID_W-1:0]),
    .rsp_valid     (rsp_valid),
    .rsp_code      (rsp_code),
    .rsp_thread    (rsp_thread),
    .resume_valid  (resume_valid),
    .resume_thread (resume_thread)
  );

  p_one_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  p_resume_after_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|resume_valid) |-> $past(sel_any && sel_unlock));

  genvar g;
  generate
    for (g = 0; g < NUM_PROC; g++) begin : g_chk
      p_rsp_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[g] && req_ready[g]) |=> rsp_valid[g]);
      p_no_stray_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid[g] && req_ready[g]) |=> !rsp_valid[g]);
      if (g > 0) begin : g_lose
        p_loser_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
          (req_valid[g] && |req_valid[g-1:0]) |-> !req_ready[g]);
      end
    end
  endgenerate
endmodule

// File: tb/tb_hw_mutex_unit.sv
module tb_hw_mutex_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req_valid = '0;
  logic [1:0] req_ready;
  logic [1:0] req_unlock = '0;
  logic [3:0] req_thread = '0;
  logic [7:0] req_mutex = '0;
  logic [1:0] rsp_valid;
  logic [3:0] rsp_code;
  logic [3:0] rsp_thread;
  logic [1:0] resume_valid;
  logic [3:0] resume_thread;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit       m_held [16];
  int       m_owner[16];
  bit [7:0] m_wait [16];

  always #2.5 clk = ~clk;

  hw_mutex_unit dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_unlock(req_unlock),
    .req_thread(req_thread), .req_mutex(req_mutex),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_thread(rsp_thread),
    .resume_valid(resume_valid), .resume_thread(resume_thread)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(int code, bit u, int pick);
    if (code == 1) return "R2";
    if (code == 2) return "R3";
    if (code == 3) return u ? "R6" : "R7";
    return (pick >= 0) ? "R5" : "R4";
  endfunction

  // model step: returns expected code, sets resumed thread (or -1)
  task automatic model(bit u, int g, int m, output int code, output int pick);
    pick = -1;
    if (!u) begin
      if (!m_held[m]) begin code = 1; m_held[m] = 1; m_owner[m] = g; end
      else if (m_owner[m] == g) code = 3;
      else begin code = 2; m_wait[m][g] = 1'b1; end
    end else begin
      if (!m_held[m] || m_owner[m] != g) code = 3;
      else begin
        code = 0;
        for (int i = 1; i <= 8; i++) begin
          int c = (g + i) % 8;
          if (pick < 0 && m_wait[m][c]) pick = c;
        end
        if (pick >= 0) begin m_owner[m] = pick; m_wait[m][pick] = 1'b0; end
        else m_held[m] = 0;
      end
    end
  endtask

  task automatic check_resp(int p, int lt, int code, bit u, int pick);
    string t = tag_of(code, u, pick);
    chk("R9 rsp_valid", rsp_valid[p], 1);
    chk("R9 other rsp", rsp_valid[1-p], 0);
    chk({t, " code"}, rsp_code[p*2 +: 2], code);
    chk("R9 rsp_thread", rsp_thread[p*2 +: 2], lt);
    if (pick >= 0) begin
      chk("R10 resume_valid", resume_valid, 1 << (pick / 4));
      chk("R10 resume_thread", resume_thread[(pick/4)*2 +: 2], pick % 4);
    end else begin
      chk({t, " no resume"}, resume_valid, 0);
    end
  endtask

  task automatic do_op(int p, bit u, int lt, int m);
    int code, pick;
    req_valid[p] = 1'b1;
    req_unlock[p] = u;
    req_thread[p*2 +: 2] = 2'(lt);
    req_mutex[p*4 +: 4] = 4'(m);
    #1;
    chk("R9 ready", req_ready[p], 1);
    model(u, p*4 + lt, m, code, pick);
    @(posedge clk);
    @(negedge clk);
    req_valid[p] = 1'b0;
    check_resp(p, lt, code, u, pick);
  endtask

  task automatic do_g(bit u, int g, int m);
    do_op(g / 4, u, g % 4, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 16; m++) begin m_held[m] = 0; m_owner[m] = 0; m_wait[m] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 resume_valid", resume_valid, 0);
    // R1: fresh mutexes grant on first lock
    do_g(0, 3, 9);
    do_g(1, 3, 9);

    // main sweep: every mutex, every owner
    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < 8; t++) begin
        do_g(0, t, m);                              // R2
        for (int k = 1; k < 8; k++) do_g(0, (t + k*3) % 8, m);  // R3
        do_g(0, t, m);                              // R7
        do_g(1, (t + 1) % 8, m);                    // R6 non-owner
        for (int k = 0; k < 8; k++) do_g(1, m_owner[m], m);     // R5 then R4
        do_g(1, t, m);                              // R6 free
      end
    end

    // R8: collision on one mutex
    @(negedge clk);
    req_valid = 2'b11; req_unlock = 2'b00;
    req_thread = {2'd2, 2'd1}; req_mutex = {4'd5, 4'd5};
    #1;
    chk("R8 ready p0", req_ready[0], 1);
    chk("R8 ready p1", req_ready[1], 0);
    @(posedge clk); @(negedge clk);
    req_valid[0] = 1'b0;
    chk("R8 p0 rsp", rsp_valid, 2'b01);
    chk("R8 p0 grant", rsp_code[1:0], 1);
    #1;
    chk("R8 p1 ready", req_ready[1], 1);
    @(posedge clk); @(negedge clk);
    req_valid[1] = 1'b0;
    chk("R8 p1 rsp", rsp_valid, 2'b10);
    chk("R8 p1 suspend", rsp_code[3:2], 2);
    m_held[5] = 1; m_owner[5] = 1; m_wait[5] = 8'h40;
    do_g(1, 1, 5);   // R5: wakes thread 6 on processor 1
    do_g(1, 6, 5);   // R4
    @(negedge clk);
    chk("R9 idle", rsp_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule